// File: doc/BRIEF.md
# Endpoint Configuration Space with Linked Capabilities

This block is the configuration register file of a single-function endpoint. It answers dword-aligned reads and writes through a plain request port. A read returns data combinationally for the byte offset on `cfg_addr`. A write takes effect at the next rising clock edge while `cfg_wr_en` is high. Offsets 0x00 to 0x3F hold a type 0 header. Above the header sits a chain of four capability structures in a fixed order: power management, message signalled interrupts (MSI), the PCIe capability, then MSI-X. Each structure starts at a parameterised base offset and spans a parameterised number of dwords.

Every access is compared against the header range and against each capability's range. The matching structure's register is returned or updated. Offsets that no structure covers read as zero, and writes to them change nothing. This includes the gaps between capabilities and the whole extended region from 0x100 up to the end of the 4 KB space. Each register bit is either writable or read-only. Byte enables select which bytes of the writable bits a write may change.

Top module: `cfg_space_responder`

## Requirements
- R1: Offset 0x00 always reads {DEVICE_ID[31:16], VENDOR_ID[15:0]} and ignores writes. Offset 0x04 bit 20 (capability list present) reads 1. Offset 0x0C bits [23:16] (header type) read 0x00.
- R2: Offset 0x34 bits [7:0] read the base offset of the power management capability, which is the first capability in the chain.
- R3: Dword 0 of each capability holds its ID in bits [7:0] and the next structure's offset in bits [15:8]. The IDs are power management 0x01, MSI 0x05, PCIe 0x10 and MSI-X 0x11. The next pointers follow that order, and the MSI-X next pointer is 0x00.
- R4: A capability serves only offsets from its base up to, but not including, base + 4*size. All other offsets from 0x40 up to the top of the address space read 0, and writes to them are ignored.
- R5: The PCIe capability reports the following values. Dword 1 bits [2:0] = 001 (256-byte payload). Dword 3 bits [3:0] = 1 (2.5 GT/s) and bits [9:4] = 1 (x1). Dword 4 bits [19:16] = 1 and bits [25:20] = 1 (current speed and width).
- R6: At reset the following fields read 0. Power management dword 1 bits [1:0] (power state) and bit 8 (wake enable). MSI dword 0 bit 16 (enable). MSI-X dword 0 bit 31 (enable) and bit 30 (function mask).
- R7: A write changes only the bytes whose `cfg_be` bit is set. A write with `cfg_be` = 0 changes nothing.
- R8: Read-only bits, including IDs, capability IDs, next pointers and reported link properties, keep their value under any write.
- R9: The writable bits are listed below. Every other bit is read-only.
  - Header: offset 0x04 bits 0, 1, 2 and 10; offset 0x0C bits [7:0]; offset 0x10 bits [31:17]; offset 0x3C bits [7:0].
  - Power management dword 1: bits 0, 1 and 8.
  - MSI: dword 0 bit 16; dword 1 bits [31:2]; dword 2 bits [31:0]; dword 3 bits [15:0].
  - PCIe: dword 2 bits [7:5] and [14:12], reset value 0x00002000; dword 4 bits [1:0].
  - MSI-X: dword 0 bits 31 and 30.
- R10: A synchronous reset (`rst` high at a clock edge) returns every register to its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | ADDR_W (12) | Byte offset of the access; bits [1:0] are ignored |
| cfg_wr_en | input | 1 | Write strobe, sampled at the rising edge |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |

## Verification
The bench builds the block with its default parameters. ADDR_W is 12, and the capabilities sit at 0x40 (2 dwords), 0x50 (4 dwords), 0x70 (5 dwords) and 0x90 (3 dwords). With these values, every one of the 1024 dwords of the 4 KB space is swept in each phase. That covers both ends of every capability range, the gaps between them and the extended region above 0x100. The sweeps compare each dword against values computed from the requirements. They read every dword after reset, after all-ones writes, after partial byte-enable writes, after writes with no byte enabled, and after a second reset.

// File: rtl/cfg_space_pkg.sv
`timescale 1ns/1ps
package cfg_space_pkg;

    typedef enum logic [2:0] {
        RGN_HDR  = 3'd0,
        RGN_PM   = 3'd1,
        RGN_MSI  = 3'd2,
        RGN_PCIE = 3'd3,
        RGN_MSIX = 3'd4
    } region_e;

    localparam int NUM_RGN  = 5;
    localparam int HDR_NDW  = 16;
    localparam int DW_IDX_W = 4;

    localparam logic [7:0] CAPID_PM   = 8'h01;
    localparam logic [7:0] CAPID_MSI  = 8'h05;
    localparam logic [7:0] CAPID_PCIE = 8'h10;
    localparam logic [7:0] CAPID_MSIX = 8'h11;

    typedef struct packed {
        logic [NUM_RGN-1:0]  hit;
        logic [DW_IDX_W-1:0] idx;
    } cfg_sel_t;

    // Reset value of dword idx within region r
    function automatic logic [31:0] rgn_reset(region_e r, int idx, logic [7:0] nxt,
                                              logic [31:0] ident, logic [31:0] class_rev,
                                              logic [7:0] cap_ptr);
        logic [31:0] v;
        v = '0;
        case (r)
            RGN_HDR: begin
                case (idx)
                    0:       v = ident;
                    1:       v = 32'h0010_0000;
                    2:       v = class_rev;
                    13:      v = {24'h0, cap_ptr};
                    15:      v = 32'h0000_0100;
                    default: v = '0;
                endcase
            end
            RGN_PM:   if (idx == 0) v = {16'h0003, nxt, CAPID_PM};
            RGN_MSI:  if (idx == 0) v = {16'h0080, nxt, CAPID_MSI};
            RGN_PCIE: begin
                case (idx)
                    0:       v = {16'h0002, nxt, CAPID_PCIE};
                    1:       v = 32'h0000_0001;
                    2:       v = 32'h0000_2000;
                    3:       v = 32'h0000_0011;
                    4:       v = 32'h0011_0000;
                    default: v = '0;
                endcase
            end
            RGN_MSIX: begin
                case (idx)
                    0:       v = {16'h0004, nxt, CAPID_MSIX};
                    1:       v = 32'h0000_0003;
                    2:       v = 32'h0000_2003;
                    default: v = '0;
                endcase
            end
            default: v = '0;
        endcase
        return v;
    endfunction

    // Writable bits of dword idx within region r
    function automatic logic [31:0] rgn_wmask(region_e r, int idx);
        logic [31:0] m;
        m = '0;
        case (r)
            RGN_HDR: begin
                case (idx)
                    1:       m = 32'h0000_0407;
                    3:       m = 32'h0000_00FF;
                    4:       m = 32'hFFFE_0000;
                    15:      m = 32'h0000_00FF;
                    default: m = '0;
                endcase
            end
            RGN_PM:   if (idx == 1) m = 32'h0000_0103;
            RGN_MSI: begin
                case (idx)
                    0:       m = 32'h0001_0000;
                    1:       m = 32'hFFFF_FFFC;
                    2:       m = 32'hFFFF_FFFF;
                    3:       m = 32'h0000_FFFF;
                    default: m = '0;
                endcase
            end
            RGN_PCIE: begin
                case (idx)
                    2:       m = 32'h0000_70E0;
                    4:       m = 32'h0000_0003;
                    default: m = '0;
                endcase
            end
            RGN_MSIX: if (idx == 0) m = 32'hC000_0000;
            default:  m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
`timescale 1ns/1ps
module cfg_addr_decode
    import cfg_space_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int PM_BASE   = 'h40,
    parameter int PM_NDW    = 2,
    parameter int MSI_BASE  = 'h50,
    parameter int MSI_NDW   = 4,
    parameter int PCIE_BASE = 'h70,
    parameter int PCIE_NDW  = 5,
    parameter int MSIX_BASE = 'h90,
    parameter int MSIX_NDW  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output cfg_sel_t          sel
);
    localparam int RGN_BASE [NUM_RGN] = '{0, PM_BASE, MSI_BASE, PCIE_BASE, MSIX_BASE};
    localparam int RGN_NDW  [NUM_RGN] = '{HDR_NDW, PM_NDW, MSI_NDW, PCIE_NDW, MSIX_NDW};

    logic [ADDR_W:0]     addr_x;
    logic [NUM_RGN-1:0]  hit;
    logic [DW_IDX_W-1:0] rel [NUM_RGN];

    assign addr_x = {1'b0, addr};

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
        localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(RGN_BASE[g]);
        localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(RGN_BASE[g] + 4*RGN_NDW[g]);
        logic [ADDR_W:0] diff;
        assign diff   = addr_x - LO;
        assign hit[g] = (addr_x >= LO) && (addr_x < HI);
        assign rel[g] = diff[DW_IDX_W+1:2];
    end

    always_comb begin
        sel.hit = hit;
        sel.idx = '0;
        for (int g = 0; g < NUM_RGN; g++) begin
            if (hit[g]) sel.idx = rel[g];
        end
    end
endmodule

// File: rtl/cfg_reg_bank.sv
`timescale 1ns/1ps
module cfg_reg_bank
    import cfg_space_pkg::*;
#(
    parameter region_e     KIND      = RGN_HDR,
    parameter int          NDW       = 16,
    parameter logic [7:0]  NEXT_PTR  = 8'h00,
    parameter logic [31:0] IDENT     = 32'h0,
    parameter logic [31:0] CLASS_REV = 32'h0,
    parameter logic [7:0]  CAP_PTR   = 8'h00
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel,
    input  logic [DW_IDX_W-1:0] idx,
    input  logic                wr_en,
    input  logic [3:0]          be,
    input  logic [31:0]         wdata,
    output logic [31:0]         rd_data
);
    logic [31:0] words [NDW];

    for (genvar i = 0; i < NDW; i++) begin : g_dw
        localparam logic [31:0] RST_V = rgn_reset(KIND, i, NEXT_PTR, IDENT, CLASS_REV, CAP_PTR);
        localparam logic [31:0] WMASK = rgn_wmask(KIND, i);
        logic [31:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= RST_V;
            end else if (sel && wr_en && (idx == DW_IDX_W'(i))) begin
                for (int b = 0; b < 4; b++) begin
                    if (be[b]) begin
                        q[b*8 +: 8] <= (q[b*8 +: 8] & ~WMASK[b*8 +: 8]) |
                                       (wdata[b*8 +: 8] & WMASK[b*8 +: 8]);
                    end
                end
            end
        end
        assign words[i] = q;
    end

    always_comb begin
        rd_data = '0;
        if (sel) begin
            for (int i = 0; i < NDW; i++) begin
                if (idx == DW_IDX_W'(i)) rd_data = words[i];
            end
        end
    end
endmodule

// File: rtl/cfg_space_responder.sv
`timescale 1ns/1ps
module cfg_space_responder
    import cfg_space_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter logic [15:0] VENDOR_ID = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID = 16'h0C3D,
    parameter logic [31:0] CLASS_REV = 32'h0200_0001,
    parameter int          PM_BASE   = 'h40,
    parameter int          PM_NDW    = 2,
    parameter int          MSI_BASE  = 'h50,
    parameter int          MSI_NDW   = 4,
    parameter int          PCIE_BASE = 'h70,
    parameter int          PCIE_NDW  = 5,
    parameter int          MSIX_BASE = 'h90,
    parameter int          MSIX_NDW  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr_en,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata
);
    localparam logic [31:0] IDENT = {DEVICE_ID, VENDOR_ID};
    localparam region_e KINDS [NUM_RGN] = '{RGN_HDR, RGN_PM, RGN_MSI, RGN_PCIE, RGN_MSIX};
    localparam int      NDWS  [NUM_RGN] = '{HDR_NDW, PM_NDW, MSI_NDW, PCIE_NDW, MSIX_NDW};
    localparam int      NEXTS [NUM_RGN] = '{0, MSI_BASE, PCIE_BASE, MSIX_BASE, 0};

    cfg_sel_t    sel;
    logic [31:0] bank_rd [NUM_RGN];

    cfg_addr_decode #(
        .ADDR_W(ADDR_W),
        .PM_BASE(PM_BASE),     .PM_NDW(PM_NDW),
        .MSI_BASE(MSI_BASE),   .MSI_NDW(MSI_NDW),
        .PCIE_BASE(PCIE_BASE), .PCIE_NDW(PCIE_NDW),
        .MSIX_BASE(MSIX_BASE), .MSIX_NDW(MSIX_NDW)
    ) u_dec (
        .addr(cfg_addr),
        .sel (sel)
    );

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_bank
        cfg_reg_bank #(
            .KIND     (KINDS[g]),
            .NDW      (NDWS[g]),
            .NEXT_PTR (8'(NEXTS[g])),
            .IDENT    (IDENT),
            .CLASS_REV(CLASS_REV),
            .CAP_PTR  (8'(PM_BASE))
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .sel    (sel.hit[g]),
            .idx    (sel.idx),
            .wr_en  (cfg_wr_en),
            .be     (cfg_be),
            .wdata  (cfg_wdata),
            .rd_data(bank_rd[g])
        );
    end

    always_comb begin
        cfg_rdata = '0;
        for (int g = 0; g < NUM_RGN; g++) cfg_rdata |= bank_rd[g];
    end
endmodule

// File: rtl/cfg_space_checks.sv
`timescale 1ns/1ps
module cfg_space_checks #(
    parameter int          ADDR_W    = 12,
    parameter logic [15:0] VENDOR_ID = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID = 16'h0C3D,
    parameter int          PM_BASE   = 'h40,
    parameter int          PM_NDW    = 2,
    parameter int          MSI_BASE  = 'h50,
    parameter int          MSI_NDW   = 4,
    parameter int          PCIE_BASE = 'h70,
    parameter int          PCIE_NDW  = 5,
    parameter int          MSIX_BASE = 'h90,
    parameter int          MSIX_NDW  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              cfg_wr_en,
    input logic [3:0]        cfg_be,
    input logic [31:0]       cfg_wdata,
    input logic [31:0]       cfg_rdata
);
    logic [ADDR_W:0] a;
    logic            covered;

    assign a = {1'b0, cfg_addr};

    always_comb begin
        covered = (a < (ADDR_W+1)'('h40)) ||
                  (a >= (ADDR_W+1)'(PM_BASE)   && a < (ADDR_W+1)'(PM_BASE + 4*PM_NDW))     ||
                  (a >= (ADDR_W+1)'(MSI_BASE)  && a < (ADDR_W+1)'(MSI_BASE + 4*MSI_NDW))   ||
                  (a >= (ADDR_W+1)'(PCIE_BASE) && a < (ADDR_W+1)'(PCIE_BASE + 4*PCIE_NDW)) ||
                  (a >= (ADDR_W+1)'(MSIX_BASE) && a < (ADDR_W+1)'(MSIX_BASE + 4*MSIX_NDW));
    end

    // R1: identity dword is constant
    p_ident_ro_r1: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr[ADDR_W-1:2] == '0) |-> (cfg_rdata == {DEVICE_ID, VENDOR_ID}));

    // R4: uncovered offsets read zero
    p_unmapped_zero_r4: assert property (@(posedge clk) disable iff (rst)
        !covered |-> (cfg_rdata == 32'h0));

    // R3: last capability terminates the chain
    p_chain_end_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr[ADDR_W-1:2] == (ADDR_W-2)'(MSIX_BASE >> 2)) |-> (cfg_rdata[15:8] == 8'h00));

    // R7: a write with no byte enabled leaves the addressed dword unchanged
    p_no_be_no_change_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_wr_en) && ($past(cfg_be) == 4'b0) && !$past(rst) && $stable(cfg_addr))
        |-> $stable(cfg_rdata));

    // R8: without a write, read data of a held address does not change
    p_read_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(cfg_wr_en) && !$past(rst) && $stable(cfg_addr)) |-> $stable(cfg_rdata));

    // R2: header capability pointer names the first capability
    p_cap_ptr_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr[ADDR_W-1:2] == (ADDR_W-2)'('h34 >> 2)) |-> (cfg_rdata[7:0] == 8'(PM_BASE)));

    logic unused_ok;
    assign unused_ok = ^cfg_wdata;
endmodule

bind cfg_space_responder cfg_space_checks #(
    .ADDR_W(ADDR_W), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
    .PM_BASE(PM_BASE), .PM_NDW(PM_NDW), .MSI_BASE(MSI_BASE), .MSI_NDW(MSI_NDW),
    .PCIE_BASE(PCIE_BASE), .PCIE_NDW(PCIE_NDW), .MSIX_BASE(MSIX_BASE), .MSIX_NDW(MSIX_NDW)
) i_checks (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr_en(cfg_wr_en),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
);

// File: tb/test_cfg_space_responder.sv
`timescale 1ns/1ps
module test_cfg_space_responder;
    localparam int          ADDR_W = 12;
    localparam int          NWORDS = 1 << (ADDR_W - 2);
    localparam logic [15:0] VID    = 16'h1A2B;
    localparam logic [15:0] DID    = 16'h0C3D;
    localparam logic [31:0] CREV   = 32'h0200_0001;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic              cfg_wr_en = 1'b0;
    logic [3:0]        cfg_be = 4'h0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] shadow [NWORDS];

    always #4 clk = ~clk;

    cfg_space_responder i_cfg_space_responder (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr_en(cfg_wr_en),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    // Reset values per byte offset, from R1, R2, R3, R5, R6 and R9
    function automatic logic [31:0] exp_rst(int off);
        case (off)
            'h00: return {DID, VID};
            'h04: return 32'h0010_0000;
            'h08: return CREV;
            'h34: return 32'h0000_0040;
            'h3C: return 32'h0000_0100;
            'h40: return 32'h0003_5001;
            'h50: return 32'h0080_7005;
            'h70: return 32'h0002_9010;
            'h74: return 32'h0000_0001;
            'h78: return 32'h0000_2000;
            'h7C: return 32'h0000_0011;
            'h80: return 32'h0011_0000;
            'h90: return 32'h0004_0011;
            'h94: return 32'h0000_0003;
            'h98: return 32'h0000_2003;
            default: return 32'h0;
        endcase
    endfunction

    // Writable bits per byte offset, from R9
    function automatic logic [31:0] exp_msk(int off);
        case (off)
            'h04: return 32'h0000_0407;
            'h0C: return 32'h0000_00FF;
            'h10: return 32'hFFFE_0000;
            'h3C: return 32'h0000_00FF;
            'h44: return 32'h0000_0103;
            'h50: return 32'h0001_0000;
            'h54: return 32'hFFFF_FFFC;
            'h58: return 32'hFFFF_FFFF;
            'h5C: return 32'h0000_FFFF;
            'h78: return 32'h0000_70E0;
            'h80: return 32'h0000_0003;
            'h90: return 32'hC000_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rst_tag(int off);
        if (off == 'h00 || off == 'h04 || off == 'h0C) return "R1";
        if (off == 'h34) return "R2";
        if (off == 'h40 || off == 'h50 || off == 'h70 || off == 'h90) return "R3";
        if (off == 'h74 || off == 'h7C || off == 'h80) return "R5";
        if (off == 'h44) return "R6";
        if (off >= 'h40 && exp_rst(off) == 0 && exp_msk(off) == 0) return "R4";
        return "R9";
    endfunction

    function automatic string wr_tag(int off);
        if (exp_msk(off) != 0) return "R9";
        if (off >= 'h40 && exp_rst(off) == 0) return "R4";
        return "R8";
    endfunction

    task automatic check(input string tag, input int off, input logic [31:0] exp);
        n_checks++;
        if (cfg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s off=0x%03h got=0x%08h exp=0x%08h", tag, off, cfg_rdata, exp);
        end
    endtask

    task automatic do_write(input int off, input logic [3:0] be, input logic [31:0] wd);
        logic [31:0] m;
        @(negedge clk);
        cfg_addr  = ADDR_W'(off);
        cfg_be    = be;
        cfg_wdata = wd;
        cfg_wr_en = 1'b1;
        m = exp_msk(off);
        for (int b = 0; b < 4; b++) begin
            if (be[b])
                shadow[off>>2][b*8 +: 8] = (shadow[off>>2][b*8 +: 8] & ~m[b*8 +: 8]) |
                                           (wd[b*8 +: 8] & m[b*8 +: 8]);
        end
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic read_chk(input int off, input string tag);
        @(negedge clk);
        cfg_addr = ADDR_W'(off);
        #1;
        check(tag, off, shadow[off>>2]);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NWORDS; i++) shadow[i] = exp_rst(i*4);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        apply_reset();

        // Reset state sweep over the whole space (R1 R2 R3 R4 R5 R6)
        for (int i = 0; i < NWORDS; i++) read_chk(i*4, rst_tag(i*4));

        // All-ones writes: writable bits set, read-only bits kept (R8 R9 R4)
        for (int i = 0; i < NWORDS; i++) do_write(i*4, 4'hF, 32'hFFFF_FFFF);
        for (int i = 0; i < NWORDS; i++) read_chk(i*4, wr_tag(i*4));

        // Partial byte enables (R7)
        for (int i = 0; i < NWORDS; i++) do_write(i*4, 4'b0101, 32'h1234_5600);
        for (int i = 0; i < NWORDS; i++) read_chk(i*4, "R7");

        // No byte enabled: nothing changes (R7)
        for (int i = 0; i < NWORDS; i++) do_write(i*4, 4'b0000, 32'h0000_0000);
        for (int i = 0; i < NWORDS; i++) read_chk(i*4, "R7");

        // Upper bytes only, zero data (R7 R6 enables cleared by write)
        for (int i = 0; i < NWORDS; i++) do_write(i*4, 4'b1010, 32'h0000_0000);
        for (int i = 0; i < NWORDS; i++) read_chk(i*4, "R7");

        // Second reset returns everything to defaults (R10)
        apply_reset();
        for (int i = 0; i < NWORDS; i++) read_chk(i*4, "R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule